// File: doc/BRIEF.md
# Chip Reset Sequencer with Domain Masking

This block gathers five reset requests and drives one reset line for each of seven chip domains. The five requests are a cold power-on pin, a warm pin, a max request from the serial interconnect, a system request from the debug port and a CPU-local request from the host port. When several requests are active together, the most inclusive one decides which domains go into reset. A cold request is not trusted on its own. Its low pulse must cover a programmable number of ticks from one of two reference clocks, and a strap input picks which clock supplies the ticks. A pulse that is too short raises a sticky error flag, and the chip stays fully in reset until a long enough pulse has finished.

All requests pass through two-flop synchronisers. Domain resets are driven from registers. The power-on pin also forces every domain into reset combinationally, so cold assertion does not wait for a clock. A one-cycle strobe tells the configuration latch when to capture the strap pins. Peripheral enables return to the boot selection whenever the peripheral domain is in reset, and afterwards they are opened one bit at a time by state-control set bits.

Top module: `chip_rst_ctrl`

## Requirements
- R1: While the power-on pin is low, all seven domain outputs are 1 in the same cycle, with no clock edge needed. While the power-on request has not been qualified, all domains also stay asserted, including `rst_test` and `pad_hiz`.
- R2: `por_good` rises only after a release of the power-on pin whose low pulse counted at least POR_MIN_TICKS selected ticks. Ticks are counted on clock edges at which the synchronised request is active.
- R3: With `ref2_off`=0 the ticks come from `ref2_tick`. With `ref2_off`=1 they come from `ref1_tick`.
- R4: A released power-on pulse with fewer than POR_MIN_TICKS ticks sets `por_short_err`. The flag stays set until `rst`, and all domains remain asserted.
- R5: A warm request asserts `rst_mem`, `rst_cfg`, `rst_periph` and `rst_cpu`. It leaves `rst_test`, `rst_pll2` and `pad_hiz` at 0.
- R6: A max request asserts exactly the same domains as a warm request.
- R7: A system request asserts only `rst_pll2` and `rst_cpu`. Memory, configuration, peripheral, test and pad domains are kept.
- R8: A CPU-local request asserts only `rst_cpu`.
- R9: Priority between simultaneous requests runs cold, then warm, then max, then system, then CPU-local.
- R10: A non-cold request changes the registered domain outputs at the third rising clock edge after the input changes. A request held across a single edge is still honoured.
- R11: `cfg_strobe` is a one-cycle pulse in the first cycle in which `rst_cfg` has dropped from 1 to 0 under register control.
- R12: While `rst_periph` is asserted, `periph_en` equals `boot_sel`. Otherwise each cycle ORs in `en_set`, and bits are never cleared. System and CPU-local resets therefore leave `periph_en` untouched.
- R13: A synchronous `rst` clears both flags and the strobe, clears `periph_en`, and asserts every domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controlling clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| por_n | input | 1 | Power-on request, active low |
| warm_n | input | 1 | Warm reset request, active low |
| max_req | input | 1 | Max reset request from the interconnect |
| sys_req | input | 1 | System reset request from the debug port |
| cpu_req | input | 1 | CPU-local reset request from the host port |
| ref1_tick | input | 1 | One-cycle tick from the first reference clock |
| ref2_tick | input | 1 | One-cycle tick from the second reference clock |
| ref2_off | input | 1 | Strap: second reference is off, count on the first |
| boot_sel | input | NUM_PERIPH | Peripherals enabled for boot |
| en_set | input | NUM_PERIPH | State-control set bits for peripheral enables |
| rst_test | output | 1 | Test/emulation domain reset |
| rst_pll2 | output | 1 | Second PLL domain reset |
| rst_mem | output | 1 | Memory retention domain reset |
| rst_cfg | output | 1 | Configuration latch domain reset |
| rst_periph | output | 1 | Peripheral domain reset |
| rst_cpu | output | 1 | CPU core reset |
| pad_hiz | output | 1 | Pad tri-state control |
| por_good | output | 1 | Power-on request qualified |
| por_short_err | output | 1 | Sticky error: power-on pulse too short |
| cfg_strobe | output | 1 | One-cycle configuration capture strobe |
| periph_en | output | NUM_PERIPH | Peripheral enable vector |

## Verification
A request toggled at time t reaches the first synchroniser flop at the next rising edge and the second flop at the edge after that. The registered domain outputs, `cfg_strobe` and `periph_en` then change at the third edge. `por_good` and `por_short_err` change at the third edge after release, and the domain outputs follow one edge later. The only exception is a low power-on pin, which asserts every domain within the same cycle. The bench updates a behavioural model with that latency at every rising edge. It changes inputs 2 ns after the falling edge and compares all outputs with the model at each falling edge, so every comparison sees settled values from the most recent rising edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_DOM = 7;
  localparam int D_TEST = 0;
  localparam int D_PLL2 = 1;
  localparam int D_MEM  = 2;
  localparam int D_CFG  = 3;
  localparam int D_PER  = 4;
  localparam int D_CPU  = 5;
  localparam int D_PAD  = 6;

  typedef logic [NUM_DOM-1:0] dom_t;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_CPU, SRC_SYS, SRC_MAX, SRC_WARM, SRC_COLD
  } src_e;

  localparam dom_t MASK_ALL  = '1;
  localparam dom_t MASK_WARM = dom_t'((1 << D_MEM) | (1 << D_CFG) | (1 << D_PER) | (1 << D_CPU));
  localparam dom_t MASK_SYS  = dom_t'((1 << D_PLL2) | (1 << D_CPU));
  localparam dom_t MASK_CPU  = dom_t'(1 << D_CPU);

  function automatic dom_t dom_mask(src_e s);
    case (s)
      SRC_COLD: return MASK_ALL;
      SRC_WARM,
      SRC_MAX:  return MASK_WARM;
      SRC_SYS:  return MASK_SYS;
      SRC_CPU:  return MASK_CPU;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/rstc_por_qual.sv
module rstc_por_qual #(
  parameter int MIN_TICKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic cold_s,
  input  logic tick,
  output logic ok,
  output logic err
);
  localparam int CW = $clog2(MIN_TICKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_TICKS);

  logic [CW-1:0] cnt;
  logic          prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      prev <= 1'b0;
      ok   <= 1'b0;
      err  <= 1'b0;
    end else begin
      prev <= cold_s;
      if (cold_s) begin
        ok <= 1'b0;
        if (cnt != CMAX) cnt <= cnt + CW'(tick);
      end else begin
        cnt <= '0;
        if (prev) begin
          if (cnt == CMAX) ok <= 1'b1;
          else err <= 1'b1;
        end
      end
    end
  end

  p_ok_needs_count_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ok) |-> ($past(cnt) == CMAX));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/rstc_prio.sv
module rstc_prio
  import rstc_pkg::*;
(
  input  logic cold,
  input  logic warm,
  input  logic maxr,
  input  logic sys,
  input  logic cpu,
  output dom_t mask
);
  src_e win;
  always_comb begin
    if (cold)      win = SRC_COLD;
    else if (warm) win = SRC_WARM;
    else if (maxr) win = SRC_MAX;
    else if (sys)  win = SRC_SYS;
    else if (cpu)  win = SRC_CPU;
    else           win = SRC_NONE;
    mask = dom_mask(win);
  end
endmodule

// File: rtl/chip_rst_ctrl.sv
module chip_rst_ctrl
  import rstc_pkg::*;
#(
  parameter int POR_MIN_TICKS = 256,
  parameter int NUM_PERIPH    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  por_n,
  input  logic                  warm_n,
  input  logic                  max_req,
  input  logic                  sys_req,
  input  logic                  cpu_req,
  input  logic                  ref1_tick,
  input  logic                  ref2_tick,
  input  logic                  ref2_off,
  input  logic [NUM_PERIPH-1:0] boot_sel,
  input  logic [NUM_PERIPH-1:0] en_set,
  output logic                  rst_test,
  output logic                  rst_pll2,
  output logic                  rst_mem,
  output logic                  rst_cfg,
  output logic                  rst_periph,
  output logic                  rst_cpu,
  output logic                  pad_hiz,
  output logic                  por_good,
  output logic                  por_short_err,
  output logic                  cfg_strobe,
  output logic [NUM_PERIPH-1:0] periph_en
);
  localparam int NUM_SRC = 5;

  logic [NUM_SRC-1:0] raw, req_s;
  logic               tick_sel;
  dom_t               mask_nxt, dom_q, dom_out;

  assign raw = {cpu_req, sys_req, max_req, ~warm_n, ~por_n};

  rstc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(req_s)
  );

  assign tick_sel = ref2_off ? ref1_tick : ref2_tick;

  rstc_por_qual #(.MIN_TICKS(POR_MIN_TICKS)) u_qual (
    .clk(clk), .rst(rst), .cold_s(req_s[0]), .tick(tick_sel),
    .ok(por_good), .err(por_short_err)
  );

  rstc_prio u_prio (
    .cold(req_s[0] | ~por_good), .warm(req_s[1]), .maxr(req_s[2]),
    .sys(req_s[3]), .cpu(req_s[4]), .mask(mask_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q      <= MASK_ALL;
      cfg_strobe <= 1'b0;
      periph_en  <= '0;
    end else begin
      dom_q      <= mask_nxt;
      cfg_strobe <= dom_q[D_CFG] & ~mask_nxt[D_CFG];
      if (mask_nxt[D_PER]) periph_en <= boot_sel;
      else                 periph_en <= periph_en | en_set;
    end
  end

  assign dom_out    = dom_q | {NUM_DOM{~por_n}};
  assign rst_test   = dom_out[D_TEST];
  assign rst_pll2   = dom_out[D_PLL2];
  assign rst_mem    = dom_out[D_MEM];
  assign rst_cfg    = dom_out[D_CFG];
  assign rst_periph = dom_out[D_PER];
  assign rst_cpu    = dom_out[D_CPU];
  assign pad_hiz    = dom_out[D_PAD];

  p_unqualified_all_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!por_good) |-> (&dom_q));
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |=> !cfg_strobe);
  p_strobe_at_release_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |-> (!dom_q[D_CFG] && $past(dom_q[D_CFG])));
  p_pen_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (!dom_q[D_PER] && !$past(dom_q[D_PER])) |-> ((periph_en & $past(periph_en)) == $past(periph_en)));
endmodule

// File: tb/test_chip_rst_ctrl.sv
module test_chip_rst_ctrl;
  localparam int MIN = 256;
  localparam int NP  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_n = 1'b1, warm_n = 1'b1, max_req = 1'b0, sys_req = 1'b0, cpu_req = 1'b0;
  logic ref1_tick = 1'b0, ref2_tick = 1'b0, ref2_off = 1'b0;
  logic [NP-1:0] boot_sel = 8'h05, en_set = '0;
  logic rst_test, rst_pll2, rst_mem, rst_cfg, rst_periph, rst_cpu, pad_hiz;
  logic por_good, por_short_err, cfg_strobe;
  logic [NP-1:0] periph_en;

  chip_rst_ctrl #(.POR_MIN_TICKS(MIN), .NUM_PERIPH(NP)) i_chip_rst_ctrl (
    .clk(clk), .rst(rst), .por_n(por_n), .warm_n(warm_n), .max_req(max_req),
    .sys_req(sys_req), .cpu_req(cpu_req), .ref1_tick(ref1_tick), .ref2_tick(ref2_tick),
    .ref2_off(ref2_off), .boot_sel(boot_sel), .en_set(en_set),
    .rst_test(rst_test), .rst_pll2(rst_pll2), .rst_mem(rst_mem), .rst_cfg(rst_cfg),
    .rst_periph(rst_periph), .rst_cpu(rst_cpu), .pad_hiz(pad_hiz),
    .por_good(por_good), .por_short_err(por_short_err), .cfg_strobe(cfg_strobe),
    .periph_en(periph_en)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R13";
  bit done = 0;

  // behavioural model: bit 0 test, 1 pll2, 2 mem, 3 cfg, 4 periph, 5 cpu, 6 pad
  bit [4:0] q1, q2;
  bit       m_prev, m_ok, m_err, m_stb;
  int       m_cnt;
  bit [6:0] m_dom;
  bit [NP-1:0] m_pen;

  always @(posedge clk) begin
    bit [4:0] rawv;
    bit tk, cold;
    bit [6:0] nm;
    rawv = {cpu_req, sys_req, max_req, ~warm_n, ~por_n};
    if (rst) begin
      q1 = 0; q2 = 0; m_prev = 0; m_ok = 0; m_err = 0; m_stb = 0;
      m_cnt = 0; m_dom = 7'h7F; m_pen = 0;
    end else begin
      tk   = ref2_off ? ref1_tick : ref2_tick;
      cold = q2[0] | !m_ok;
      if (cold)       nm = 7'h7F;
      else if (q2[1]) nm = 7'h3C;
      else if (q2[2]) nm = 7'h3C;
      else if (q2[3]) nm = 7'h22;
      else if (q2[4]) nm = 7'h20;
      else            nm = 7'h00;
      m_stb = m_dom[3] & !nm[3];
      m_pen = nm[4] ? boot_sel : (m_pen | en_set);
      m_dom = nm;
      if (q2[0]) begin
        m_ok = 0;
        if (m_cnt < MIN) m_cnt = m_cnt + int'(tk);
      end else begin
        if (m_prev) begin
          if (m_cnt >= MIN) m_ok = 1; else m_err = 1;
        end
        m_cnt = 0;
      end
      m_prev = q2[0];
      q2 = q1;
      q1 = rawv;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit [6:0] exp_dom;
    if (!done) begin
      exp_dom = m_dom | (por_n ? 7'h00 : 7'h7F);
      chk(cur_req, int'({pad_hiz, rst_cpu, rst_periph, rst_cfg, rst_mem, rst_pll2, rst_test}),
          int'(exp_dom), "domains");
      chk(rst ? "R13" : "R2", int'(por_good), int'(m_ok), "por_good");
      chk("R4", int'(por_short_err), int'(m_err), "por_short_err");
      chk("R11", int'(cfg_strobe), int'(m_stb), "cfg_strobe");
      chk("R12", int'(periph_en), int'(m_pen), "periph_en");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic report;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    cyc(3);
    // R13: reset state, then unqualified stays fully in reset (R1)
    rst = 0; cur_req = "R1";
    cyc(10);
    // R2: valid pulse counted on ref2 ticks, ref1 idle
    cur_req = "R2"; ref2_tick = 1; por_n = 0;
    cyc(MIN + 20);
    por_n = 1; cyc(12);
    // R5 warm
    cur_req = "R5"; warm_n = 0; cyc(8); warm_n = 1; cyc(8);
    en_set = 8'h30; cyc(1); en_set = 0; cyc(3);
    // R6 max
    cur_req = "R6"; max_req = 1; cyc(8); max_req = 0; cyc(8);
    en_set = 8'h42; cyc(1); en_set = 0; cyc(3);
    // R7 system keeps peripheral enables (R12)
    cur_req = "R7"; sys_req = 1; cyc(8); sys_req = 0; cyc(8);
    // R8 cpu local
    cur_req = "R8"; cpu_req = 1; cyc(8); cpu_req = 0; cyc(8);
    // R10 single-cycle request
    cur_req = "R10"; cpu_req = 1; cyc(1); cpu_req = 0; cyc(8);
    sys_req = 1; cyc(1); sys_req = 0; cyc(8);
    // R9 priority
    cur_req = "R9"; cpu_req = 1; sys_req = 1; cyc(6);
    max_req = 1; cyc(6); warm_n = 0; cyc(6);
    max_req = 0; cyc(4); warm_n = 1; cyc(4);
    sys_req = 0; cyc(4); cpu_req = 0; cyc(8);
    // R1 asynchronous cold assertion, combined with R9 cold priority
    cur_req = "R1"; cpu_req = 1; por_n = 0; cyc(3);
    por_n = 1; cpu_req = 0; cyc(10);
    // R4 short pulse: error, stays in reset
    cur_req = "R4"; por_n = 0; cyc(60); por_n = 1; cyc(20);
    // R3 ref2 off: ticks from ref1 every other cycle, ref2 silent
    cur_req = "R3"; ref2_off = 1; ref2_tick = 0; por_n = 0;
    for (int i = 0; i < 2 * MIN + 40; i++) begin
      ref1_tick = i[0]; cyc(1);
    end
    ref1_tick = 0; por_n = 1; cyc(12);
    // R3 pulse long in clocks but few ref1 ticks: too short
    por_n = 0; cyc(MIN + 10); por_n = 1; cyc(12);
    cur_req = "R13"; rst = 1; cyc(3); rst = 0; cyc(4);
    report();
  end
endmodule